// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block takes an asynchronous DRAM from reset to operating state and then keeps its contents alive. After reset it holds every strobe inactive for the power-up settling period. It then runs a fixed number of warm-up refresh cycles on its own, and finally raises `init_done_o`. From that point a free-running interval timer asks for one CAS-before-RAS refresh per interval. The default interval is 15.625 µs, or 125 µs when the low-power rate is selected.

Once initialization is over, the block shares the strobes with an access controller through a request/grant pair. A refresh that falls due is counted as pending and raises `req_o`. The strobe sequence starts only after `gnt_i` is sampled high. Refreshes that pile up while the controller holds the bus are counted up to a cap. When the grant comes they are issued back-to-back. `we_n_o` is held high for the whole of every refresh cycle, so the device always sees a plain refresh and never a test-mode entry. Every nanosecond limit is converted to clock cycles from the `CLK_NS` parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `req_o` and `init_done_o` are 0.
- R2: After reset is released, the strobes stay high and `req_o` stays low for ceil(T_PWRUP_NS/CLK_NS) cycles. The first CAS fall comes exactly one cycle after that wait ends.
- R3: After the wait, exactly N_WARM (default 8) refresh cycles run back-to-back without looking at `gnt_i`. `init_done_o` rises one cycle after the last precharge ends and then stays high until reset.
- R4: In every refresh cycle, CAS falls at least ceil(5 ns/CLK_NS) cycles before RAS falls. CAS stays low at least ceil(10 ns/CLK_NS) cycles after RAS falls, and rises while RAS is still low.
- R5: `we_n_o` is 1 in every cycle.
- R6: RAS is low for at least ceil(60 ns/CLK_NS) cycles and high for at least ceil(40 ns/CLK_NS) cycles between its low periods. Successive RAS falls are at least ceil(110 ns/CLK_NS) cycles apart.
- R7: After `init_done_o` rises, one refresh falls due every floor(REFI_NS/CLK_NS) cycles. REFI_NS is 15625 ns by default and 125000 ns when LOW_POWER=1. With a grant that is always available, RAS falls are spaced exactly that far apart.
- R8: After initialization, `req_o` is 1 whenever a refresh is pending or a refresh cycle is in progress, and 0 otherwise. A refresh cycle starts, with CAS falling, only in the cycle after `gnt_i` was sampled 1 together with a pending refresh. With `gnt_i` low no strobe moves.
- R9: Pending refreshes saturate at MAX_PEND (default 8). After a long hold-off, a grant yields exactly MAX_PEND refresh cycles spaced C_BUSY+1 cycles apart, where C_BUSY is the length of one cycle, and then `req_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus granted to refresh by the access controller |
| req_o | output | 1 | Refresh wants the bus |
| init_done_o | output | 1 | Power-up and warm-up complete |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
Every result here has a fixed latency counted in rising edges. A due refresh shows on `req_o` after the edge that ends its interval. CAS falls one edge after a sampled grant. RAS follows ceil(5 ns/CLK_NS) edges later. `init_done_o` rises one edge after the last warm-up precharge state. The reference model advances on each rising edge from the sampled `gnt_i` and queues the strobe pattern of each cycle it starts. All outputs are compared on the falling edge that follows, so every expected value sits in the same cycle in which the registered outputs change. Event timestamps from the same falling-edge sampling give the minimum-width, interval and back-to-back spacing checks.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {PH_WAIT, PH_WARM, PH_RUN} phase_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_ACT, SQ_PRE} seq_state_e;

  function automatic int ns2cyc_up(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PWRUP_CYC = 20000,
  parameter int REFI_CYC  = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic pwr_ok_o,
  output logic tick_o
);
  localparam int PW_W = $clog2(PWRUP_CYC + 1);
  localparam int RF_W = $clog2(REFI_CYC + 1);

  logic [PW_W-1:0] pw_q;
  logic [RF_W-1:0] rf_q;

  assign pwr_ok_o = (pw_q == PW_W'(PWRUP_CYC - 1));
  assign tick_o   = run_i && (rf_q == RF_W'(REFI_CYC - 1));

  // power-up counter holds at its limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pw_q <= '0;
    else if (!pwr_ok_o) pw_q <= pw_q + 1'b1;
  end

  // interval counter runs only in the operating phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rf_q <= '0;
    else if (!run_i)  rf_q <= '0;
    else if (tick_o)  rf_q <= '0;
    else              rf_q <= rf_q + 1'b1;
  end

  generate
    if (REFI_CYC > 1) begin : g_gap
      p_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/dram_ref_pend.sv
module dram_ref_pend #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nz_o = (cnt_q != '0);

  // saturating up/down count of refreshes owed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i) begin
      if (cnt_q != CNT_W'(MAX_PEND)) cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_pend_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_PEND));

  p_pend_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
    (cnt_q == $past(cnt_q) - 1'b1));

  p_no_under_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> nz_o);

endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 1,
  parameter int RAS_CYC = 6,
  parameter int PRE_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int LONG = max2(max2(CSR_CYC, RAS_CYC), PRE_CYC);
  localparam int CW   = $clog2(LONG + 1);

  seq_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          ras_q, cas_q;

  assign busy_o  = (st_q != SQ_IDLE);
  assign ras_n_o = ras_q;
  assign cas_n_o = cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q  <= SQ_LEAD;
          cas_q <= 1'b0;
          cnt_q <= CW'(CSR_CYC - 1);
        end
        SQ_LEAD: if (cnt_q == '0) begin
          st_q  <= SQ_ACT;
          ras_q <= 1'b0;
          cnt_q <= CW'(RAS_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SQ_ACT: begin
          // release CAS once RAS has been low for the hold time
          if (cnt_q == CW'(RAS_CYC - CHR_CYC)) cas_q <= 1'b1;
          if (cnt_q == '0) begin
            st_q  <= SQ_PRE;
            ras_q <= 1'b1;
            cnt_q <= CW'(PRE_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        SQ_PRE: if (cnt_q == '0) st_q <= SQ_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  p_cbr_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_q) |-> !cas_q);

  p_cas_rel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_q) |-> !ras_q);

  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_q) |-> $past(st_q) == SQ_IDLE);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter bit LOW_POWER     = 1'b0,
  parameter int N_WARM        = 8,
  parameter int MAX_PEND      = 8,
  parameter int T_PWRUP_NS    = 200000,
  parameter int T_REFI_STD_NS = 15625,
  parameter int T_REFI_LP_NS  = 125000,
  parameter int T_CSR_NS      = 5,
  parameter int T_CHR_NS      = 10,
  parameter int T_RAS_NS      = 60,
  parameter int T_RP_NS       = 40,
  parameter int T_RC_NS       = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  output logic req_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int C_CSR   = ns2cyc_up(T_CSR_NS, CLK_NS);
  localparam int C_CHR   = ns2cyc_up(T_CHR_NS, CLK_NS);
  localparam int C_RAS   = max2(ns2cyc_up(T_RAS_NS, CLK_NS), C_CHR);
  localparam int C_PRE   = max2(ns2cyc_up(T_RP_NS, CLK_NS),
                                ns2cyc_up(T_RC_NS, CLK_NS) - C_RAS);
  localparam int C_BUSY  = C_CSR + C_RAS + C_PRE;
  localparam int C_PWRUP = ns2cyc_up(T_PWRUP_NS, CLK_NS);
  localparam int REFI_NS = LOW_POWER ? T_REFI_LP_NS : T_REFI_STD_NS;
  localparam int C_REFI  = max2(REFI_NS / CLK_NS, C_BUSY + 1);
  localparam int PEND_W  = $clog2(MAX_PEND + 1);
  localparam int WARM_W  = $clog2(N_WARM + 1);

  phase_e            ph_q;
  logic [WARM_W-1:0] warm_q;
  logic              pwr_ok, tick, pend_nz;
  logic              seq_busy, seq_idle, seq_start, run_start, run;

  assign run       = (ph_q == PH_RUN);
  assign seq_idle  = !seq_busy;
  assign run_start = run && seq_start;

  always_comb begin
    seq_start = 1'b0;
    case (ph_q)
      PH_WARM: seq_start = seq_idle && (warm_q != '0);
      PH_RUN:  seq_start = seq_idle && pend_nz && gnt_i;
      default: seq_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_WAIT;
      warm_q <= WARM_W'(N_WARM);
    end else begin
      case (ph_q)
        PH_WAIT: if (pwr_ok) ph_q <= PH_WARM;
        PH_WARM: begin
          if (seq_start)                     warm_q <= warm_q - 1'b1;
          else if (seq_idle && warm_q == '0) ph_q <= PH_RUN;
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end

  dram_ref_timer #(
    .PWRUP_CYC (C_PWRUP),
    .REFI_CYC  (C_REFI)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .pwr_ok_o (pwr_ok),
    .tick_o   (tick)
  );

  dram_ref_pend #(
    .MAX_PEND (MAX_PEND),
    .CNT_W    (PEND_W)
  ) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (run_start),
    .nz_o   (pend_nz)
  );

  dram_ref_seq #(
    .CSR_CYC (C_CSR),
    .CHR_CYC (C_CHR),
    .RAS_CYC (C_RAS),
    .PRE_CYC (C_PRE)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seq_start),
    .busy_o  (seq_busy),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  assign init_done_o = run;
  assign req_o       = run && (pend_nz || seq_busy);
  assign we_n_o      = 1'b1;  // never a test-mode entry

  p_quiet_powerup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WAIT) |-> (ras_n_o && cas_n_o && !req_o));

  p_done_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_grant_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && $fell(cas_n_o)) |-> $past(gnt_i));

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int CLK_NS    = 5;
  localparam int C_CSR     = (5 + CLK_NS - 1) / CLK_NS;
  localparam int C_CHR     = (10 + CLK_NS - 1) / CLK_NS;
  localparam int C_RAS     = (60 + CLK_NS - 1) / CLK_NS;
  localparam int C_RP      = (40 + CLK_NS - 1) / CLK_NS;
  localparam int C_RC      = (110 + CLK_NS - 1) / CLK_NS;
  localparam int C_PRE     = (C_RP > C_RC - C_RAS) ? C_RP : C_RC - C_RAS;
  localparam int C_BUSY    = C_CSR + C_RAS + C_PRE;
  localparam int C_PWRUP   = (200000 + CLK_NS - 1) / CLK_NS;
  localparam int C_REFI    = 15625 / CLK_NS;
  localparam int C_REFI_LP = 125000 / CLK_NS;
  localparam int N_WARM    = 8;
  localparam int MAXP      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, done, ras, cas, we;
  logic lp_req, lp_done, lp_ras, lp_cas, lp_we;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(.CLK_NS(CLK_NS)) u_dram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req),
    .init_done_o(done), .ras_n_o(ras), .cas_n_o(cas), .we_n_o(we));

  dram_refresh_sched #(.CLK_NS(CLK_NS), .LOW_POWER(1'b1)) u_dram_refresh_sched_lp (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(1'b1), .req_o(lp_req),
    .init_done_o(lp_done), .ras_n_o(lp_ras), .cas_n_o(lp_cas), .we_n_o(lp_we));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int gmode = 0;  // 0 hold off, 1 follow req, 2 always grant
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) gnt <= (gmode == 1) ? req : (gmode == 2);

  // reference model, advanced on each rising edge
  int m_pw, m_phase, m_warm, m_pend, m_refc;
  bit m_ras = 1, m_cas = 1, m_busy = 0;
  bit m_idle, m_st, m_tick;
  logic [2:0] q[$];
  logic [2:0] ent;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pw = 0; m_phase = 0; m_warm = N_WARM; m_pend = 0; m_refc = 0;
      m_ras = 1; m_cas = 1; m_busy = 0; q.delete();
    end else begin
      m_idle = !m_busy; m_st = 0; m_tick = 0;
      case (m_phase)
        0: begin m_pw++; if (m_pw == C_PWRUP) m_phase = 1; end
        1: if (m_idle) begin
             if (m_warm > 0) begin m_st = 1; m_warm--; end
             else m_phase = 2;
           end
        default: begin
          m_tick = (m_refc == C_REFI - 1);
          m_refc = m_tick ? 0 : m_refc + 1;
          if (m_idle && m_pend > 0 && gnt) m_st = 1;
          if (m_tick && !m_st) begin if (m_pend < MAXP) m_pend++; end
          else if (m_st && !m_tick) m_pend--;
        end
      endcase
      if (m_st)
        for (int i = 0; i < C_BUSY; i++)
          q.push_back({!(i >= C_CSR && i < C_CSR + C_RAS), !(i < C_CSR + C_CHR), 1'b1});
      if (q.size() > 0) begin
        ent = q.pop_front();
        m_ras = ent[2]; m_cas = ent[1]; m_busy = ent[0];
      end else begin
        m_ras = 1; m_cas = 1; m_busy = 0;
      end
    end
  end

  // comparison and port-level event timing
  int falls[$];
  int lp_falls[$];
  int warm_falls = 0;
  int first_cas = -1, last_cas_fall = -1, last_ras_fall = -1, last_ras_rise = -1;
  logic p_ras = 1, p_cas = 1, p_lp_ras = 1;

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(ras == m_ras, "R4 ras_n vs model", ras, m_ras);
      chk(cas == m_cas, "R4 cas_n vs model", cas, m_cas);
      chk(we == 1'b1, "R5 we_n high", we, 1);
      chk(lp_we == 1'b1, "R5 we_n high low-power", lp_we, 1);
      chk(req == (m_phase == 2 && (m_pend > 0 || m_busy)), "R8 req vs model",
          req, (m_phase == 2 && (m_pend > 0 || m_busy)));
      chk(done == (m_phase == 2), "R3 init_done vs model", done, (m_phase == 2));
      if (p_cas && !cas) begin
        last_cas_fall = cyc;
        if (first_cas < 0) first_cas = cyc;
      end
      if (!p_cas && cas)
        chk(!ras && (cyc - last_ras_fall >= C_CHR), "R4 cas hold after ras",
            cyc - last_ras_fall, C_CHR);
      if (p_ras && !ras) begin
        chk(!cas && (cyc - last_cas_fall >= C_CSR), "R4 cas lead", cyc - last_cas_fall, C_CSR);
        if (last_ras_rise >= 0) chk(cyc - last_ras_rise >= C_RP, "R6 ras precharge",
                                    cyc - last_ras_rise, C_RP);
        if (last_ras_fall >= 0) chk(cyc - last_ras_fall >= C_RC, "R6 ras cycle",
                                    cyc - last_ras_fall, C_RC);
        last_ras_fall = cyc;
        falls.push_back(cyc);
        if (!done) warm_falls++;
      end
      if (!p_ras && ras) begin
        chk(cyc - last_ras_fall >= C_RAS, "R6 ras active width", cyc - last_ras_fall, C_RAS);
        last_ras_rise = cyc;
      end
      if (p_lp_ras && !lp_ras && lp_done) lp_falls.push_back(cyc);
    end
    p_ras = ras; p_cas = cas; p_lp_ras = lp_ras;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    step(3);
    chk(ras == 1'b1, "R1 ras_n in reset", ras, 1);
    chk(cas == 1'b1, "R1 cas_n in reset", cas, 1);
    chk(we == 1'b1, "R1 we_n in reset", we, 1);
    chk(req == 1'b0, "R1 req in reset", req, 0);
    chk(done == 1'b0, "R1 init_done in reset", done, 0);
    rst_n = 1'b1;
    while (!done) step(1);
    chk(first_cas == C_PWRUP + 1, "R2 first cas after power-up wait", first_cas, C_PWRUP + 1);
    chk(warm_falls == N_WARM, "R3 warm-up refresh count", warm_falls, N_WARM);

    // follow-the-request grant: one refresh per interval
    gmode = 1; falls.delete();
    step(3 * C_REFI + 100);
    chk(falls.size() == 3, "R7 refreshes per interval", falls.size(), 3);
    for (int i = 1; i < falls.size(); i++)
      chk(falls[i] - falls[i-1] == C_REFI, "R7 refresh spacing", falls[i] - falls[i-1], C_REFI);

    // bus held: nothing moves, requests accumulate
    gmode = 0; falls.delete();
    step(11 * C_REFI);
    chk(falls.size() == 0, "R8 no strobe without grant", falls.size(), 0);
    chk(req == 1'b1, "R8 req held while pending", req, 1);

    // grant returns: saturated backlog drains back-to-back
    gmode = 1; falls.delete();
    step(MAXP * (C_BUSY + 1) + 200);
    chk(falls.size() == MAXP, "R9 drained refresh count", falls.size(), MAXP);
    for (int i = 1; i < falls.size(); i++)
      chk(falls[i] - falls[i-1] == C_BUSY + 1, "R9 back-to-back spacing",
          falls[i] - falls[i-1], C_BUSY + 1);
    chk(req == 1'b0, "R9 req released after drain", req, 0);

    // permanent grant, then the low-power instance interval
    gmode = 2;
    step(2 * C_REFI);
    while (lp_falls.size() < 3) step(1);
    for (int i = 1; i < 3; i++)
      chk(lp_falls[i] - lp_falls[i-1] == C_REFI_LP, "R7 low-power spacing",
          lp_falls[i] - lp_falls[i-1], C_REFI_LP);
    fin = 1'b1;
    summary();
  end

endmodule